// File: doc/BRIEF.md
# Page-Aligned Flash Transfer Splitter

This block sits in front of a flash command sequencer and turns one host transfer request (start address, byte count, direction) into a series of buffer-sized flash commands. Write requests are cut so that no piece crosses a flash page boundary. Read requests are cut only by the size of the sequencer's data buffer.

For each write piece, the block takes the bytes from a byte stream and packs them into 32-bit buffer words. It then programs the piece address and issues the raw-write command. For each read piece, it programs the address, issues the raw-read command, and after completion streams the buffer contents out byte by byte.

The block waits for the sequencer's completion pulse after every command. A missing completion ends the request with a timeout status. A reported error ends the request at once. The host gets exactly one response per request.

Top module: `flash_xfer_splitter`

## Requirements
- R1: A write piece has length PAGE_BYTES minus (current address mod PAGE_BYTES), limited to the bytes still remaining. It is issued with opcode 0x02.
- R2: A read piece has length min(remaining, PAGE_BYTES) and is issued with opcode 0x03. In both directions the command length field carries the piece byte count.
- R3: For a write piece, every buffer word of the piece is written first, then the address is programmed, then the command is issued.
- R4: For a read piece, the address is programmed and the command issued with no buffer writes. The buffer is read only after completion, and the bytes leave on the read stream in ascending address order.
- R5: After each completed piece, the address advances by the piece length. When nothing remains, one response with status 0 (OK) is given and held until accepted.
- R6: After issuing a command the block waits for completion. If none arrives within TIMEOUT_CYC cycles, the request ends with status 2 (TIMEOUT) and no further command is issued.
- R7: A request of length zero responds with status 0 and issues no command, address or buffer access.
- R8: A completion flagged with an error ends the request with status 1 (ERROR) and no further command is issued.
- R9: Buffer words are big-endian: the piece byte at offset 4k+j sits in bits [31-8j -: 8] of word k. The unused lanes of a partial last word are 0xFF.
- R10: After reset the block is ready for a request, with no response, command, address or buffer strobe active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken |
| resp_status | output | 2 | 0 OK, 1 ERROR, 2 TIMEOUT |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| buf_we | output | 1 | Buffer word write strobe |
| buf_widx | output | PAGE_W-2 | Buffer word index for writes |
| buf_wdata | output | 32 | Buffer word written |
| buf_re | output | 1 | Buffer word read strobe |
| buf_ridx | output | PAGE_W-2 | Buffer word index for reads |
| buf_rdata | input | 32 | Read word, valid the cycle after buf_re |
| adr_we | output | 1 | Address program strobe |
| adr_val | output | ADDR_W | Piece address |
| cmd_valid | output | 1 | Command issue strobe |
| cmd_op | output | 7 | Command opcode |
| cmd_len | output | PAGE_W+1 | Piece byte count |
| cmd_done | input | 1 | Command completion pulse |
| cmd_err | input | 1 | Completion carries an error |

## Verification
Page-crossing writes that start at odd offsets are the hardest to reach. So are reads that end mid-word, where the piece boundary and the word boundary disagree. The bench sweeps start addresses at and around page edges against lengths around 1, 4, 256 and multiples of the page, in both directions. A sequencer model checks every piece's address, length, ordering and padding as each command arrives. Timeout and error endings need a sequencer that misbehaves. The model can be switched to withhold completion or to flag an error on the first piece of a multi-piece request.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam logic [6:0] OP_WRITE = 7'h02;
  localparam logic [6:0] OP_READ  = 7'h03;

  typedef enum logic [1:0] {
    STAT_OK      = 2'd0,
    STAT_ERR     = 2'd1,
    STAT_TIMEOUT = 2'd2
  } xfer_status_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CALC, S_FILL, S_SETADR, S_ISSUE, S_WAIT,
    S_RFETCH, S_RWAIT, S_RLOAD, S_EMIT, S_NEXT, S_RESP
  } xfer_state_t;
endpackage

// File: rtl/piece_sizer.sv
module piece_sizer #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int PAGE_W = 8,
  localparam int CLEN_W = PAGE_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remain,
  input  logic              is_write,
  output logic [CLEN_W-1:0] piece
);
  localparam logic [CLEN_W-1:0] PAGE = CLEN_W'(1) << PAGE_W;

  logic [CLEN_W-1:0] room;

  always_comb begin
    // Writes stop at the page edge; reads stop only at buffer capacity.
    if (is_write) room = PAGE - {1'b0, addr[PAGE_W-1:0]};
    else          room = PAGE;
    if (remain < {{(LEN_W-CLEN_W){1'b0}}, room}) piece = remain[CLEN_W-1:0];
    else                                         piece = room;
  end
endmodule

// File: rtl/be_packer.sv
module be_packer (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        en,
  input  logic [1:0]  lane,
  input  logic [7:0]  byte_in,
  output logic [31:0] word_next
);
  logic [31:0] word_q;

  always_comb begin
    word_next = word_q;
    if (en) begin
      for (int j = 0; j < 4; j++)
        if (lane == 2'(j)) word_next[31-8*j -: 8] = byte_in;
    end
  end

  // Lanes never written keep the 0xFF fill.
  always_ff @(posedge clk) begin
    if (rst || flush) word_q <= '1;
    else if (en)      word_q <= word_next;
  end
endmodule

// File: rtl/flash_xfer_splitter.sv
module flash_xfer_splitter
  import xfer_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 16,
  parameter int PAGE_BYTES  = 256,
  parameter int TIMEOUT_CYC = 1000,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int CLEN_W = PAGE_W + 1,
  localparam int WIDX_W = PAGE_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [1:0]        resp_status,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              buf_we,
  output logic [WIDX_W-1:0] buf_widx,
  output logic [31:0]       buf_wdata,
  output logic              buf_re,
  output logic [WIDX_W-1:0] buf_ridx,
  input  logic [31:0]       buf_rdata,
  output logic              adr_we,
  output logic [ADDR_W-1:0] adr_val,
  output logic              cmd_valid,
  output logic [6:0]        cmd_op,
  output logic [CLEN_W-1:0] cmd_len,
  input  logic              cmd_done,
  input  logic              cmd_err
);
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CLEN_W-1:0] PAGE = CLEN_W'(PAGE_BYTES);

  xfer_state_t       state_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [CLEN_W-1:0] piece_q, piece_w, cnt_q;
  logic [TO_W-1:0]   timer_q;
  logic [31:0]       rword_q, word_next;
  logic [1:0]        stat_q;
  logic              take_byte, last_byte, pack_flush;

  piece_sizer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) i_sizer (
    .addr(addr_q), .remain(rem_q), .is_write(write_q), .piece(piece_w)
  );

  assign take_byte  = (state_q == S_FILL) && wr_valid;
  assign last_byte  = (cnt_q == piece_q - CLEN_W'(1));
  assign pack_flush = take_byte && (cnt_q[1:0] == 2'd3 || last_byte);

  be_packer i_packer (
    .clk(clk), .rst(rst), .flush(pack_flush), .en(take_byte),
    .lane(cnt_q[1:0]), .byte_in(wr_data), .word_next(word_next)
  );

  assign req_ready   = (state_q == S_IDLE);
  assign wr_ready    = (state_q == S_FILL);
  assign rd_valid    = (state_q == S_EMIT);
  assign resp_valid  = (state_q == S_RESP);
  assign resp_status = stat_q;

  always_comb begin
    rd_data = rword_q[31:24];
    for (int j = 1; j < 4; j++)
      if (cnt_q[1:0] == 2'(j)) rd_data = rword_q[31-8*j -: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      write_q   <= 1'b0;
      addr_q    <= '0;
      rem_q     <= '0;
      piece_q   <= '0;
      cnt_q     <= '0;
      timer_q   <= '0;
      rword_q   <= '0;
      stat_q    <= STAT_OK;
      buf_we    <= 1'b0;
      buf_widx  <= '0;
      buf_wdata <= '0;
      buf_re    <= 1'b0;
      buf_ridx  <= '0;
      adr_we    <= 1'b0;
      adr_val   <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_len   <= '0;
    end else begin
      buf_we    <= 1'b0;
      buf_re    <= 1'b0;
      adr_we    <= 1'b0;
      cmd_valid <= 1'b0;
      case (state_q)
        S_IDLE: if (req_valid) begin
          write_q <= req_write;
          addr_q  <= req_addr;
          rem_q   <= req_len;
          stat_q  <= STAT_OK;
          state_q <= (req_len == '0) ? S_RESP : S_CALC;
        end
        S_CALC: begin
          piece_q <= piece_w;
          cnt_q   <= '0;
          state_q <= write_q ? S_FILL : S_SETADR;
        end
        S_FILL: if (take_byte) begin
          cnt_q <= cnt_q + CLEN_W'(1);
          if (pack_flush) begin
            buf_we    <= 1'b1;
            buf_widx  <= cnt_q[PAGE_W-1:2];
            buf_wdata <= word_next;
          end
          if (last_byte) state_q <= S_SETADR;
        end
        S_SETADR: begin
          adr_we  <= 1'b1;
          adr_val <= addr_q;
          state_q <= S_ISSUE;
        end
        S_ISSUE: begin
          cmd_valid <= 1'b1;
          cmd_op    <= write_q ? OP_WRITE : OP_READ;
          cmd_len   <= piece_q;
          timer_q   <= '0;
          state_q   <= S_WAIT;
        end
        S_WAIT: begin
          if (cmd_done) begin
            cnt_q <= '0;
            if (cmd_err) begin
              stat_q  <= STAT_ERR;
              state_q <= S_RESP;
            end else begin
              state_q <= write_q ? S_NEXT : S_RFETCH;
            end
          end else if (timer_q == TO_W'(TIMEOUT_CYC - 1)) begin
            stat_q  <= STAT_TIMEOUT;
            state_q <= S_RESP;
          end else begin
            timer_q <= timer_q + TO_W'(1);
          end
        end
        S_RFETCH: begin
          buf_re   <= 1'b1;
          buf_ridx <= cnt_q[PAGE_W-1:2];
          state_q  <= S_RWAIT;
        end
        S_RWAIT: state_q <= S_RLOAD;
        S_RLOAD: begin
          rword_q <= buf_rdata;
          state_q <= S_EMIT;
        end
        S_EMIT: if (rd_ready) begin
          cnt_q <= cnt_q + CLEN_W'(1);
          if (last_byte)               state_q <= S_NEXT;
          else if (cnt_q[1:0] == 2'd3) state_q <= S_RFETCH;
        end
        S_NEXT: begin
          addr_q  <= addr_q + ADDR_W'(piece_q);
          rem_q   <= rem_q - LEN_W'(piece_q);
          state_q <= (rem_q == LEN_W'(piece_q)) ? S_RESP : S_CALC;
        end
        S_RESP: if (resp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_WR_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRITE) |->
      ({1'b0, {1'b0, adr_val[PAGE_W-1:0]}} + {1'b0, cmd_len}) <= {1'b0, PAGE}); // R1
  AST_PIECE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_len != '0 && cmd_len <= PAGE)); // R2
  AST_ADR_BEFORE_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(adr_we)); // R3
  AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_NEXT) |=> (rem_q < $past(rem_q))); // R5
  AST_RESP_HELD: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_status))); // R5
endmodule

// File: tb/test_flash_xfer_splitter.sv
module test_flash_xfer_splitter;
  localparam int ADDR_W = 24, LEN_W = 16, TO = 100, LAT = 5, MEMSZ = 2048;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, resp_ready = 1'b1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic req_ready, resp_valid, wr_ready, rd_valid;
  logic [1:0] resp_status;
  logic wr_valid = 1'b0, rd_ready = 1'b1;
  logic [7:0] wr_data = '0, rd_data;
  logic buf_we, buf_re, adr_we, cmd_valid;
  logic [5:0] buf_widx, buf_ridx;
  logic [31:0] buf_wdata, buf_rdata = '0;
  logic [ADDR_W-1:0] adr_val;
  logic [6:0] cmd_op;
  logic [8:0] cmd_len;
  logic cmd_done = 1'b0, cmd_err = 1'b0;

  flash_xfer_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(256), .TIMEOUT_CYC(TO))
  i_flash_xfer_splitter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_status(resp_status),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
    .buf_re(buf_re), .buf_ridx(buf_ridx), .buf_rdata(buf_rdata),
    .adr_we(adr_we), .adr_val(adr_val), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_len(cmd_len), .cmd_done(cmd_done), .cmd_err(cmd_err)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0]  flash [MEMSZ];
  logic [31:0] bufm [64];
  int exp_addr [64];
  int exp_len [64];
  int exp_n, cmd_n, words_w, countdown, fd_base, fd_len, fd_idx, rcv_n;
  int cmd_cyc, resp_cyc;
  logic [7:0] rcv [1024];
  logic adr_after, take_pend, got_resp, hang, err_mode, cur_write;
  logic [1:0] got_stat;
  logic [ADDR_W-1:0] cur_adr;

  function automatic logic [7:0] pat(int a, int s);
    return 8'((a * 7 + s * 13 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Sequencer model and stream endpoints, all acting at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (take_pend) fd_idx++;
      wr_valid = (fd_idx < fd_len);
      wr_data  = pat(fd_base + fd_idx, 1);
      take_pend = wr_valid && wr_ready;
      if (rd_valid && rd_ready && rcv_n < 1024) begin rcv[rcv_n] = rd_data; rcv_n++; end
      if (buf_we) begin bufm[buf_widx] = buf_wdata; words_w++; adr_after = 1'b0; end
      if (buf_re) buf_rdata = bufm[buf_ridx];
      if (adr_we) begin cur_adr = adr_val; adr_after = 1'b1; end
      if (cmd_done) begin cmd_done = 1'b0; cmd_err = 1'b0; end
      else if (countdown > 0) begin
        countdown--;
        if (countdown == 0) begin cmd_done = 1'b1; cmd_err = err_mode; end
      end
      if (cmd_valid) begin
        int len;
        len = int'(cmd_len);
        cmd_cyc = cyc;
        if (cmd_n < exp_n) begin
          chk(int'(cur_adr) == exp_addr[cmd_n], "R5 piece address", int'(cur_adr), exp_addr[cmd_n]);
          if (cur_write) begin
            chk(len == exp_len[cmd_n], "R1 write piece length", len, exp_len[cmd_n]);
            chk(cmd_op == 7'h02, "R1 write opcode", cmd_op, 2);
          end else begin
            chk(len == exp_len[cmd_n], "R2 read piece length", len, exp_len[cmd_n]);
            chk(cmd_op == 7'h03, "R2 read opcode", cmd_op, 3);
          end
        end else chk(1'b0, "R5 extra command", cmd_n + 1, exp_n);
        if (cmd_op == 7'h02) begin
          chk(adr_after && words_w == (len + 3) / 4, "R3 write order", words_w, (len + 3) / 4);
          for (int i = len; i < ((len + 3) / 4) * 4; i++)
            chk(bufm[i/4][31-8*(i%4) -: 8] == 8'hFF, "R9 pad byte",
                bufm[i/4][31-8*(i%4) -: 8], 255);
          for (int i = 0; i < len; i++)
            flash[(int'(cur_adr) + i) % MEMSZ] = bufm[i/4][31-8*(i%4) -: 8];
        end else begin
          chk(adr_after && words_w == 0, "R4 read order", words_w, 0);
          for (int i = 0; i < len; i++)
            bufm[i/4][31-8*(i%4) -: 8] = flash[(int'(cur_adr) + i) % MEMSZ];
        end
        for (int k = 0; k < 64; k++) if (cmd_op == 7'h02) bufm[k] = '0;
        words_w = 0; adr_after = 1'b0;
        cmd_n++;
        if (!hang) countdown = LAT;
      end
      if (resp_valid && !got_resp) begin got_resp = 1'b1; got_stat = resp_status; resp_cyc = cyc; end
    end
  end

  task automatic run_req(input bit wr, input int addr, input int len);
    int a, r, p;
    @(negedge clk); #2;
    exp_n = 0; a = addr; r = len;
    while (r > 0) begin
      p = wr ? 256 - (a % 256) : 256;
      if (p > r) p = r;
      exp_addr[exp_n] = a; exp_len[exp_n] = p;
      exp_n++; a += p; r -= p;
    end
    cmd_n = 0; rcv_n = 0; words_w = 0; got_resp = 1'b0; adr_after = 1'b0;
    cur_write = wr; fd_base = addr; fd_idx = 0; take_pend = 1'b0;
    fd_len = wr ? len : 0;
    req_write = wr; req_addr = ADDR_W'(addr); req_len = LEN_W'(len); req_valid = 1'b1;
    while (!req_ready) begin @(negedge clk); #2; end
    @(posedge clk); #2;
    req_valid = 1'b0;
    while (!got_resp) @(negedge clk);
    fd_len = 0;
  endtask

  initial begin
    int addrs [8] = '{0, 1, 3, 4, 129, 255, 256, 510};
    int lens [10] = '{1, 2, 3, 4, 5, 7, 255, 256, 257, 513};
    int mism;
    for (int i = 0; i < MEMSZ; i++) flash[i] = pat(i, 2);
    for (int k = 0; k < 64; k++) bufm[k] = '0;
    exp_n = 0; cmd_n = 0; words_w = 0; countdown = 0; fd_base = 0; fd_len = 0; fd_idx = 0;
    rcv_n = 0; adr_after = 0; take_pend = 0; got_resp = 0; hang = 0; err_mode = 0;
    cur_write = 0; cur_adr = '0; got_stat = '0; cmd_cyc = 0; resp_cyc = 0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !resp_valid && !cmd_valid && !adr_we && !buf_we && !buf_re,
        "R10 reset state", {req_ready, resp_valid, cmd_valid}, 3'b100);

    run_req(1'b1, 40, 0);
    chk(got_stat == 2'd0, "R7 zero-length status", got_stat, 0);
    chk(cmd_n == 0, "R7 zero-length commands", cmd_n, 0);
    run_req(1'b0, 40, 0);
    chk(cmd_n == 0 && got_stat == 2'd0, "R7 zero-length read", cmd_n, 0);

    foreach (addrs[ai]) foreach (lens[li]) begin
      run_req(1'b1, addrs[ai], lens[li]);
      chk(got_stat == 2'd0, "R5 write status", got_stat, 0);
      chk(cmd_n == exp_n, "R1 write piece count", cmd_n, exp_n);
      mism = 0;
      for (int i = 0; i < lens[li]; i++)
        if (flash[(addrs[ai] + i) % MEMSZ] != pat(addrs[ai] + i, 1)) mism++;
      chk(mism == 0, "R9 written bytes", mism, 0);
    end

    foreach (addrs[ai]) foreach (lens[li]) begin
      run_req(1'b0, addrs[ai] + 3, lens[li]);
      chk(got_stat == 2'd0, "R5 read status", got_stat, 0);
      chk(cmd_n == exp_n, "R2 read piece count", cmd_n, exp_n);
      chk(rcv_n == lens[li], "R4 read byte count", rcv_n, lens[li]);
      mism = 0;
      for (int i = 0; i < lens[li] && i < rcv_n; i++)
        if (rcv[i] != flash[(addrs[ai] + 3 + i) % MEMSZ]) mism++;
      chk(mism == 0, "R4 read byte order", mism, 0);
    end

    hang = 1'b1;
    run_req(1'b0, 100, 300);
    chk(got_stat == 2'd2, "R6 timeout status", got_stat, 2);
    chk(cmd_n == 1, "R6 no piece after timeout", cmd_n, 1);
    chk(resp_cyc - cmd_cyc >= TO, "R6 wait length", resp_cyc - cmd_cyc, TO);
    hang = 1'b0;

    err_mode = 1'b1;
    run_req(1'b1, 10, 600);
    chk(got_stat == 2'd1, "R8 error status", got_stat, 1);
    chk(cmd_n == 1, "R8 no piece after error", cmd_n, 1);
    err_mode = 1'b0;

    run_req(1'b1, 250, 20);
    chk(got_stat == 2'd0 && cmd_n == 2, "R8 recovery after error", cmd_n, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule